// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block controls an analog-to-digital converter core in continuous scan mode. Software selects a group of channels by writing the highest channel number of the group, puts the mode field in scan, and sets a run bit. The sequencer then converts channel 0, 1, and so on up to that highest channel. It keeps every result in a register owned by that channel, raises an end-of-pass flag, and starts the next pass at channel 0 straight away. The run bit is never cleared by hardware. Software, a timer pulse or an external trigger pin can set it. Only a control write of 0 stops the scan.

The converter core is reached through a pair of one-cycle pulses. A start pulse carries a channel number, and a later done pulse carries the result. At most one conversion is outstanding, so this link has no back-pressure. The sequencer always accepts a done pulse in the cycle it arrives. A done pulse that belongs to an aborted conversion is absorbed and discarded, and the next start is held back until it has arrived. Results are read through a combinational select port. The end flag can only be cleared by reading it while it is 1 and then writing 0.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, the run bit, end flag, irq and conv_start are 0, and every channel result register reads 0.
- R2: With the run bit at 1 and ctl_mode = 2'b11, conv_start pulses go to channels 0,1,...,L in ascending order, where L is ctl_last, and then wrap to 0. No start is issued while a conversion is outstanding, meaning a start has not yet been answered by conv_done.
- R3: The conv_result that arrives with conv_done in an active scan is stored in the register of the channel that was converted. rd_data shows the register chosen by rd_sel in the same cycle.
- R4: end_flag is set in the cycle after the done pulse of channel L is taken. irq is a level equal to end_flag AND the interrupt enable.
- R5: The run bit stays 1 across passes unless a control write clears it, so passes repeat without end.
- R6: A control write with ctl_start = 0 halts the scan. No further conv_start is issued. The done pulse of an aborted conversion updates no register and sets no flag, and no new start is issued before that done pulse has arrived.
- R7: Setting the run bit again, including right after an abort in flight, restarts the scan at channel 0.
- R8: A pulse on timer_trig or ext_trig sets the run bit. A trigger in the same cycle as a control write of ctl_start = 0 leaves the run bit at 1.
- R9: end_flag is cleared only by a control write with ctl_flag = 0 that follows a flag_rd pulse seen while end_flag was 1. A write of 0 without that read leaves the flag set, and a write with ctl_flag = 1 has no effect on it.
- R10: If an armed clearing write and an end-of-pass event fall in the same cycle, the flag stays 1 and the read arm is used up. A further write of 0 then needs a new read before it can clear the flag.
- R11: With the run bit at 1 and ctl_mode other than 2'b11, no conversion is issued.
- R12: Mode, highest channel and run bit may be written in one control write, and the scan that follows uses the new selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control write strobe |
| ctl_start | input | 1 | Run bit value written |
| ctl_ie | input | 1 | Interrupt enable value written |
| ctl_mode | input | 2 | Mode field written (2'b11 = scan) |
| ctl_last | input | 3 | Highest channel of the group written |
| ctl_flag | input | 1 | End flag value written (0 clears when armed) |
| flag_rd | input | 1 | Status read strobe, arms the flag clear |
| timer_trig | input | 1 | Timer trigger pulse, sets run bit |
| ext_trig | input | 1 | External trigger pulse, sets run bit |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 3 | Channel for the current conversion |
| conv_done | input | 1 | One-cycle conversion done pulse |
| conv_result | input | 10 | Conversion result, valid with conv_done |
| rd_sel | input | 3 | Result register select |
| rd_data | output | 10 | Selected result register |
| run_bit | output | 1 | Current run bit |
| end_flag | output | 1 | End-of-pass flag |
| irq | output | 1 | Interrupt request level |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the end-of-pass flag set and the armed clearing write. The bench arms the flag with a read, waits until conv_done is visible for the last channel, and drives the clearing write for that same edge. It then expects the flag to stay 1, and it expects a further unread write of 0 to leave the flag set as well. The second pair is a trigger pulse and a control write of ctl_start = 0. The bench drives both together and expects the run bit to read 1.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int MODE_W = 2;
  typedef logic [MODE_W-1:0] mode_t;
  localparam mode_t MODE_SCAN = 2'b11;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ISSUE,
    SEQ_WAIT
  } seq_state_e;
endpackage

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_scan_pkg::*;
#(
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_wr,
  input  logic           ctl_start,
  input  logic           ctl_ie,
  input  mode_t          ctl_mode,
  input  logic [CHW-1:0] ctl_last,
  input  logic           ctl_flag,
  input  logic           flag_rd,
  input  logic           timer_trig,
  input  logic           ext_trig,
  input  logic           pass_done,
  output logic           run_bit,
  output mode_t          mode,
  output logic [CHW-1:0] last,
  output logic           end_flag,
  output logic           irq
);
  logic ie;
  logic armed;
  logic zero_wr;

  // a write carrying flag value 0 is the only path that can clear the flag
  assign zero_wr = ctl_wr && !ctl_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_bit  <= 1'b0;
      ie       <= 1'b0;
      mode     <= '0;
      last     <= '0;
      end_flag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ie   <= ctl_ie;
        mode <= ctl_mode;
        last <= ctl_last;
      end
      // triggers override a simultaneous write of 0
      if (timer_trig || ext_trig) run_bit <= 1'b1;
      else if (ctl_wr)            run_bit <= ctl_start;
      // a completed pass wins over a clearing write
      if (pass_done)               end_flag <= 1'b1;
      else if (zero_wr && armed)   end_flag <= 1'b0;
      // any zero write uses up the arm; a read only arms while the flag is up
      if (zero_wr)                 armed <= 1'b0;
      else if (flag_rd && end_flag) armed <= 1'b1;
    end
  end

  assign irq = end_flag && ie;
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_bit,
  input  mode_t          mode,
  input  logic [CHW-1:0] last,
  input  logic           conv_done,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  output logic           wr_en,
  output logic [CHW-1:0] wr_chan,
  output logic           pass_done
);
  seq_state_e     state;
  logic [CHW-1:0] cur;
  logic           orphan;
  logic           active;
  logic           at_end;

  assign active = run_bit && (mode == MODE_SCAN);
  assign at_end = (cur >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      cur    <= '0;
      orphan <= 1'b0;
    end else begin
      if (conv_done) orphan <= 1'b0;
      unique case (state)
        SEQ_IDLE: begin
          // hold off while an aborted conversion is still outstanding
          if (active && !orphan) begin
            state <= SEQ_ISSUE;
            cur   <= '0;
          end
        end
        SEQ_ISSUE: state <= active ? SEQ_WAIT : SEQ_IDLE;
        SEQ_WAIT: begin
          if (!active) begin
            state  <= SEQ_IDLE;
            orphan <= !conv_done;
          end else if (conv_done) begin
            state <= SEQ_ISSUE;
            cur   <= at_end ? '0 : cur + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign conv_start = (state == SEQ_ISSUE) && active;
  assign conv_chan  = cur;
  assign wr_en      = (state == SEQ_WAIT) && active && conv_done;
  assign wr_chan    = cur;
  assign pass_done  = wr_en && at_end;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH = 8,
  parameter int DW  = 10,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_chan,
  input  logic [DW-1:0]  wr_data,
  input  logic [CHW-1:0] rd_sel,
  output logic [DW-1:0]  rd_data
);
  logic [DW-1:0] bank [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (wr_en && (wr_chan == CHW'(g)))  q <= wr_data;
    end
    assign bank[g] = q;
  end

  assign rd_data = bank[rd_sel];
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 10,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_start,
  input  logic              ctl_ie,
  input  logic [MODE_W-1:0] ctl_mode,
  input  logic [CHW-1:0]    ctl_last,
  input  logic              ctl_flag,
  input  logic              flag_rd,
  input  logic              timer_trig,
  input  logic              ext_trig,
  output logic              conv_start,
  output logic [CHW-1:0]    conv_chan,
  input  logic              conv_done,
  input  logic [DW-1:0]     conv_result,
  input  logic [CHW-1:0]    rd_sel,
  output logic [DW-1:0]     rd_data,
  output logic              run_bit,
  output logic              end_flag,
  output logic              irq
);
  mode_t          mode;
  logic [CHW-1:0] last;
  logic           pass_done;
  logic           wr_en;
  logic [CHW-1:0] wr_chan;

  adc_ctrl_regs #(.CHW(CHW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_start(ctl_start), .ctl_ie(ctl_ie),
    .ctl_mode(ctl_mode), .ctl_last(ctl_last), .ctl_flag(ctl_flag),
    .flag_rd(flag_rd), .timer_trig(timer_trig), .ext_trig(ext_trig),
    .pass_done(pass_done),
    .run_bit(run_bit), .mode(mode), .last(last),
    .end_flag(end_flag), .irq(irq)
  );

  adc_scan_fsm #(.CHW(CHW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .run_bit(run_bit), .mode(mode), .last(last), .conv_done(conv_done),
    .conv_start(conv_start), .conv_chan(conv_chan),
    .wr_en(wr_en), .wr_chan(wr_chan), .pass_done(pass_done)
  );

  adc_result_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(conv_result),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );
endmodule

// File: rtl/adc_scan_seq_sva.sv
module adc_scan_seq_sva (
  input logic clk,
  input logic rst_n,
  input logic ctl_wr,
  input logic timer_trig,
  input logic ext_trig,
  input logic conv_start,
  input logic conv_done,
  input logic run_bit,
  input logic end_flag,
  input logic irq
);
  // outstanding conversion, tracked from the handshake pins alone
  logic busy;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy <= 1'b0;
    else if (conv_start) busy <= 1'b1;
    else if (conv_done)  busy <= 1'b0;
  end

  assert_single_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !busy);

  assert_flag_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $past(conv_done));

  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> end_flag);

  assert_run_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_bit && !ctl_wr) |=> run_bit);

  assert_halt_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_bit |-> !conv_start);

  assert_trigger_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_trig || ext_trig) |=> run_bit);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !ctl_wr) |=> end_flag);
endmodule

bind adc_scan_seq adc_scan_seq_sva u_sva (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr),
  .timer_trig(timer_trig), .ext_trig(ext_trig),
  .conv_start(conv_start), .conv_done(conv_done),
  .run_bit(run_bit), .end_flag(end_flag), .irq(irq)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  localparam int NCH = 8;
  localparam int CHW = 3;
  localparam int DW  = 10;
  localparam int LAT = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic ctl_wr, ctl_start, ctl_ie, ctl_flag, flag_rd, timer_trig, ext_trig;
  logic [1:0] ctl_mode;
  logic [CHW-1:0] ctl_last, conv_chan, rd_sel;
  logic conv_start, conv_done, run_bit, end_flag, irq;
  logic [DW-1:0] conv_result, rd_data;

  adc_scan_seq #(.NCH(NCH), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_start(ctl_start),
    .ctl_ie(ctl_ie), .ctl_mode(ctl_mode), .ctl_last(ctl_last),
    .ctl_flag(ctl_flag), .flag_rd(flag_rd), .timer_trig(timer_trig),
    .ext_trig(ext_trig), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result), .rd_sel(rd_sel),
    .rd_data(rd_data), .run_bit(run_bit), .end_flag(end_flag), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;
  int epoch  = 0;
  int start_cnt = 0;
  int mon_epoch = 0;
  logic [CHW-1:0] exp_ch = '0;
  logic [CHW-1:0] cur_last = '0;
  logic [CHW-1:0] want;

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // converter core model: fixed latency, result = {channel, running count}
  int m_cnt;
  logic [CHW-1:0] m_ch;
  int m_epoch;
  logic [6:0] m_seq;
  logic [DW-1:0] exp_data [NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_ch <= '0; m_epoch <= 0; m_seq <= '0;
      conv_done <= 1'b0; conv_result <= '0;
      for (int i = 0; i < NCH; i++) exp_data[i] <= '0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) begin
        m_cnt <= LAT; m_ch <= conv_chan; m_epoch <= epoch;
      end else if (m_cnt != 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          conv_done   <= 1'b1;
          conv_result <= {m_ch, m_seq};
          m_seq       <= m_seq + 1'b1;
          if (m_epoch == epoch) exp_data[m_ch] <= {m_ch, m_seq};
        end
      end
    end
  end

  // start monitor: order, single flight, gating by run bit
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      want = (epoch != mon_epoch) ? '0 : exp_ch;
      chk(conv_chan == want, "R2 scan order", conv_chan, want);
      chk(m_cnt == 0, "R6 no start while outstanding", m_cnt, 0);
      chk(run_bit, "R6 start only while running", run_bit, 1);
      mon_epoch = epoch;
      exp_ch    = (want >= cur_last) ? '0 : want + 1'b1;
      start_cnt = start_cnt + 1;
    end
  end

  task automatic wr(input logic st, input logic ie, input logic [1:0] md,
                    input logic [CHW-1:0] lst, input logic fl);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_start = st; ctl_ie = ie; ctl_mode = md;
    ctl_last = lst; ctl_flag = fl; cur_last = lst;
    if (!st) begin #1 epoch++; end
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic wait_flag(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (end_flag) begin ok = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic wait_start(output logic [CHW-1:0] ch, output logic ok);
    ok = 1'b0; ch = '0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (conv_start) begin ch = conv_chan; ok = 1'b1; return; end
    end
  endtask

  task automatic wait_start_ch(input logic [CHW-1:0] c, output logic ok);
    logic [CHW-1:0] ch;
    ok = 1'b0;
    for (int i = 0; i < 16; i++) begin
      wait_start(ch, ok);
      if (!ok) return;
      if (ch == c) return;
    end
    ok = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NCH; i++) begin
      @(negedge clk); rd_sel = i[CHW-1:0]; #1;
      chk(rd_data == exp_data[i], tag, rd_data, exp_data[i]);
    end
  endtask

  initial begin
    #1000000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ok;
    logic [CHW-1:0] ch;
    logic [DW-1:0] snap;
    int s0;
    rst_n = 1'b0; ctl_wr = 0; ctl_start = 0; ctl_ie = 0; ctl_mode = 0;
    ctl_last = 0; ctl_flag = 1; flag_rd = 0; timer_trig = 0; ext_trig = 0;
    rd_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!run_bit, "R1 run bit", run_bit, 0);
    chk(!end_flag, "R1 end flag", end_flag, 0);
    chk(!irq, "R1 irq", irq, 0);
    chk(!conv_start, "R1 conv_start", conv_start, 0);
    for (int i = 0; i < NCH; i++) begin
      rd_sel = i[CHW-1:0]; #1;
      chk(rd_data == '0, "R1 result register", rd_data, 0);
    end

    // sweep of every group size
    for (int k = 0; k < NCH; k++) begin
      wr(1'b1, k[0], 2'b11, k[CHW-1:0], 1'b1);
      chk(run_bit, "R12 run and selection in one write", run_bit, 1);
      wait_flag(ok);
      chk(ok, "R4 end flag after pass", end_flag, 1);
      chk(irq == k[0], "R4 irq follows enable", irq, k[0]);
      s0 = start_cnt;
      for (int i = 0; i < 400 && start_cnt < s0 + 2 * (k + 1); i++) @(negedge clk);
      chk(start_cnt >= s0 + 2 * (k + 1), "R5 rescans", start_cnt - s0, 2 * (k + 1));
      chk(run_bit, "R5 run bit not self-clearing", run_bit, 1);
      wr(1'b0, k[0], 2'b11, k[CHW-1:0], 1'b1);
      repeat (LAT + 4) @(negedge clk);
      check_regs("R3 per-channel result");
      chk(end_flag, "R9 flag held after stop", end_flag, 1);
      wr(1'b0, k[0], 2'b11, k[CHW-1:0], 1'b0);
      chk(end_flag, "R9 write 0 without read", end_flag, 1);
      pulse_rd();
      wr(1'b0, k[0], 2'b11, k[CHW-1:0], 1'b1);
      chk(end_flag, "R9 write 1 no effect", end_flag, 1);
      wr(1'b0, k[0], 2'b11, k[CHW-1:0], 1'b0);
      chk(!end_flag, "R9 read then write 0 clears", end_flag, 0);
      chk(!irq, "R4 irq drops with flag", irq, 0);
    end

    // abort with a conversion in flight
    wr(1'b1, 1'b0, 2'b11, 3'd3, 1'b1);
    wait_start_ch(3'd2, ok);
    chk(ok, "R2 reached channel 2", ok, 1);
    @(negedge clk);
    rd_sel = 3'd2; #1; snap = rd_data;
    wr(1'b0, 1'b0, 2'b11, 3'd3, 1'b1);
    for (int i = 0; i < LAT + 4; i++) begin
      @(negedge clk);
      chk(!conv_start, "R6 halted", conv_start, 0);
    end
    rd_sel = 3'd2; #1;
    chk(rd_data == snap, "R6 late result dropped", rd_data, snap);
    chk(!end_flag, "R6 no flag from aborted pass", end_flag, 0);

    // restart, then restart again while a conversion is outstanding
    wr(1'b1, 1'b0, 2'b11, 3'd3, 1'b1);
    wait_start(ch, ok);
    chk(ok && ch == 0, "R7 restart at channel 0", ch, 0);
    wait_start_ch(3'd1, ok);
    @(negedge clk);
    wr(1'b0, 1'b0, 2'b11, 3'd3, 1'b1);
    wr(1'b1, 1'b0, 2'b11, 3'd3, 1'b1);
    wait_start(ch, ok);
    chk(ok && ch == 0, "R7 restart after abort in flight", ch, 0);
    wr(1'b0, 1'b0, 2'b11, 3'd3, 1'b1);
    repeat (LAT + 4) @(negedge clk);
    check_regs("R3 registers after aborts");

    // triggers
    wr(1'b0, 1'b0, 2'b11, 3'd1, 1'b1);
    @(negedge clk); timer_trig = 1'b1;
    @(negedge clk); timer_trig = 1'b0;
    chk(run_bit, "R8 timer trigger sets run", run_bit, 1);
    wait_start(ch, ok);
    chk(ok && ch == 0, "R8 trigger starts at channel 0", ch, 0);
    wr(1'b0, 1'b0, 2'b11, 3'd1, 1'b1);
    @(negedge clk); ext_trig = 1'b1;
    @(negedge clk); ext_trig = 1'b0;
    chk(run_bit, "R8 external trigger sets run", run_bit, 1);
    wr(1'b0, 1'b0, 2'b11, 3'd1, 1'b1);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_start = 1'b0; ctl_flag = 1'b1; timer_trig = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0; timer_trig = 1'b0;
    chk(run_bit, "R8 trigger beats write of 0", run_bit, 1);
    wr(1'b0, 1'b0, 2'b11, 3'd1, 1'b1);
    repeat (LAT + 4) @(negedge clk);
    pulse_rd();
    wr(1'b0, 1'b0, 2'b11, 3'd1, 1'b0);

    // modes other than scan
    wr(1'b1, 1'b0, 2'b01, 3'd7, 1'b1);
    s0 = start_cnt;
    repeat (40) @(negedge clk);
    chk(start_cnt == s0, "R11 mode 01 idle", start_cnt - s0, 0);
    wr(1'b1, 1'b0, 2'b10, 3'd7, 1'b1);
    repeat (40) @(negedge clk);
    chk(start_cnt == s0, "R11 mode 10 idle", start_cnt - s0, 0);
    wr(1'b1, 1'b0, 2'b00, 3'd7, 1'b1);
    repeat (40) @(negedge clk);
    chk(start_cnt == s0, "R11 mode 00 idle", start_cnt - s0, 0);
    wr(1'b0, 1'b0, 2'b11, 3'd0, 1'b1);

    // pass end and armed clear in the same cycle
    wr(1'b1, 1'b1, 2'b11, 3'd0, 1'b1);
    wait_flag(ok);
    chk(ok, "R4 flag for one-channel group", end_flag, 1);
    pulse_rd();
    ok = 1'b0;
    for (int i = 0; i < 400 && !ok; i++) begin
      @(negedge clk);
      ok = conv_done;
    end
    chk(ok, "R10 done pulse seen", ok, 1);
    ctl_wr = 1'b1; ctl_start = 1'b1; ctl_ie = 1'b1; ctl_mode = 2'b11;
    ctl_last = 3'd0; ctl_flag = 1'b0;
    @(negedge clk);
    ctl_wr = 1'b0;
    chk(end_flag, "R10 pass end wins over clear", end_flag, 1);
    chk(irq, "R4 irq with enable", irq, 1);
    wr(1'b1, 1'b1, 2'b11, 3'd0, 1'b0);
    chk(end_flag, "R10 arm used up", end_flag, 1);
    wr(1'b0, 1'b1, 2'b11, 3'd0, 1'b1);
    repeat (LAT + 4) @(negedge clk);
    pulse_rd();
    wr(1'b0, 1'b1, 2'b11, 3'd0, 1'b0);
    chk(!end_flag && !irq, "R9 final clear", end_flag, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule